// File: doc/BRIEF.md
# GPIO Port Interrupt Unit

This block turns the eight input lines of one GPIO port into interrupt requests. For each line, software picks level or edge sensing and the active polarity. It can enable or disable the line. Edge events that have been caught are acknowledged by writing ones to an acknowledge register. The pins are asynchronous to the block clock. They pass through a synchroniser, and edges are found by comparing each synchronised sample with the one before it.

The unit drives one request output per line and a combined request that is the OR of the per-line requests. The integrator uses whichever suits the interrupt controller it feeds. Hardware has no both-edges mode. Software gets that behaviour by inverting the polarity bit each time it acknowledges an edge.

Configuration is written through a small write port. That port carries a 2-bit register select and one data byte. Register state is not read back through this port. The pending set is visible directly on the per-line outputs.

Top module: `gpio_port_irq`

## Requirements
- R1: After synchronous reset, every sense, polarity and enable bit is 0, and no request output is active. This holds whatever the pin levels are.
- R2: Select value 0 writes the sense register. Bit n set to 1 makes line n edge-sensitive, and 0 makes it level-sensitive.
- R3: Select value 1 writes the polarity register. Bit n set to 1 means high level or rising edge, and 0 means low level or falling edge.
- R4: Select value 2 writes the enable register. A line whose enable bit is 0 never requests. While a line is disabled, its caught edge is discarded.
- R5: A level-sensitive, enabled line requests while its synchronised input equals its polarity, and no longer. The request rises or falls on the second clock edge after the pin changes.
- R6: An edge-sensitive, enabled line catches a matching transition on the third clock edge after the pin changes. It keeps requesting after the pin returns, until the edge is acknowledged.
- R7: Select value 3 is the acknowledge register. Writing it clears the caught edge of every line whose data bit is 1. Lines whose data bit is 0 keep their state.
- R8: An edge that is caught on the same clock edge as an acknowledge for that line stays caught.
- R9: Rewriting the sense or polarity register while the pin is steady creates no edge event.
- R10: `irq_line_o[n]` is the pending request of line n. `irq_any_o` is high exactly when at least one line is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_sel_i | input | 2 | Register select: 0 sense, 1 polarity, 2 enable, 3 acknowledge |
| wr_data_i | input | LINES | Write data, bit n for line n |
| pin_i | input | LINES | Asynchronous GPIO input levels |
| irq_line_o | output | LINES | Per-line pending requests |
| irq_any_o | output | 1 | OR of all per-line requests |

## Verification
The assertions assume that each write strobe lasts a single cycle. They also assume the pins are already synchronised when they reach the comparison stage. So they reason only about the sampled values, never the raw pins.

The stimulus changes pins and write signals only on the falling clock edge, so every input is stable across the sampling edge. Reconfiguration follows the disable, write, re-enable order that software uses. The one exception is the polarity-flip test, which changes polarity deliberately while the line is enabled. It does so with the pins held steady.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned PORT_LINES = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        SEL_SENSE = 2'd0,
        SEL_POL   = 2'd1,
        SEL_EN    = 2'd2,
        SEL_ACK   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic sense;  // 1 edge, 0 level
        logic pol;    // 1 high/rising, 0 low/falling
        logic en;
    } line_cfg_t;

    function automatic logic edge_match(logic pol, logic cur, logic prev);
        return pol ? (cur & ~prev) : (~cur & prev);
    endfunction

    function automatic logic level_match(logic pol, logic cur);
        return cur == pol;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en_i,
    input  logic [1:0]              wr_sel_i,
    input  logic [LINES-1:0]        wr_data_i,
    output line_cfg_t [LINES-1:0]   cfg_o,
    output logic [LINES-1:0]        ack_o
);
    logic [LINES-1:0] sense_q, pol_q, en_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(wr_sel_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            pol_q   <= '0;
            en_q    <= '0;
        end else if (wr_en_i) begin
            case (sel)
                SEL_SENSE: sense_q <= wr_data_i;
                SEL_POL:   pol_q   <= wr_data_i;
                SEL_EN:    en_q    <= wr_data_i;
                default:   ;
            endcase
        end
    end

    assign ack_o = (wr_en_i && sel == SEL_ACK) ? wr_data_i : '0;

    for (genvar n = 0; n < LINES; n++) begin : g_pack
        assign cfg_o[n] = '{sense: sense_q[n], pol: pol_q[n], en: en_q[n]};
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  line_cfg_t [LINES-1:0] cfg_i,
    input  logic [LINES-1:0]      ack_i,
    input  logic [LINES-1:0]      sync_i,
    output logic [LINES-1:0]      pend_o
);
    logic [LINES-1:0] prev_q, caught_q, hit, en_vec;

    for (genvar n = 0; n < LINES; n++) begin : g_line
        assign en_vec[n] = cfg_i[n].en;
        assign hit[n]    = cfg_i[n].en & cfg_i[n].sense
                         & edge_match(cfg_i[n].pol, sync_i[n], prev_q[n]);
        assign pend_o[n] = cfg_i[n].en & (cfg_i[n].sense ? caught_q[n]
                                          : level_match(cfg_i[n].pol, sync_i[n]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            caught_q <= '0;
        end else begin
            prev_q   <= sync_i;
            caught_q <= (caught_q & ~ack_i & en_vec) | hit;
        end
    end

    // R4: a newly caught edge needs the line enabled in the cycle before
    p_catch_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
        ((caught_q & ~$past(caught_q) & ~$past(en_vec)) == '0));

    // R7: acknowledged lines without a coincident edge are cleared
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_i != '0) |=> ((caught_q & $past(ack_i & ~hit)) == '0));

    // R8: an edge coinciding with its acknowledge remains caught
    p_edge_beats_ack_r8: assert property (@(posedge clk) disable iff (rst)
        ((hit & ack_i) != '0) |=> ((caught_q & $past(hit & ack_i)) == $past(hit & ack_i)));

    // R9: no new event on a line whose samples did not change
    p_no_event_steady_r9: assert property (@(posedge clk) disable iff (rst)
        ((caught_q & ~$past(caught_q) & ~$past(sync_i ^ prev_q)) == '0));
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_irq_pkg::*;
#(
    parameter int unsigned LINES  = PORT_LINES,
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [LINES-1:0] wr_data_i,
    input  logic [LINES-1:0] pin_i,
    output logic [LINES-1:0] irq_line_o,
    output logic             irq_any_o
);
    line_cfg_t [LINES-1:0] cfg;
    logic [LINES-1:0]      ack, sync, pend, en_vec;

    gpio_irq_sync #(.WIDTH(LINES), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(sync)
    );

    gpio_irq_cfg #(.LINES(LINES)) u_cfg (
        .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .cfg_o(cfg), .ack_o(ack)
    );

    gpio_irq_detect #(.LINES(LINES)) u_detect (
        .clk(clk), .rst(rst), .cfg_i(cfg), .ack_i(ack),
        .sync_i(sync), .pend_o(pend)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_en
        assign en_vec[n] = cfg[n].en;
    end

    assign irq_line_o = pend;
    assign irq_any_o  = |pend;

    // R4: disabled lines never show a request
    p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        ((irq_line_o & ~en_vec) == '0));

    // R1: the cycle after reset nothing is configured, so nothing requests
    p_reset_clean_r1: assert property (@(posedge clk)
        rst |=> (irq_line_o == '0));
endmodule

// File: tb/gpio_port_irq_bench.sv
module gpio_port_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LINES = 8;

    typedef struct packed {
        logic [7:0] sense, pol, en, pin_a, pin_b, exp;
    } vec_t;

    // Expected values follow R2/R3/R5/R6: level lines match pin_b to polarity,
    // edge lines need the pin_a to pin_b transition of their polarity.
    localparam vec_t VECS [6] = '{
        '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h0F},  // level high
        '{8'h00, 8'h00, 8'hF0, 8'h00, 8'h0F, 8'hF0},  // level low, half enabled
        '{8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h3C, 8'h3C},  // rising
        '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'hF0},  // falling
        '{8'hF0, 8'hCC, 8'hFF, 8'h55, 8'hAA, 8'h99},  // mixed
        '{8'hF0, 8'hCC, 8'h0F, 8'h55, 8'hAA, 8'h09}   // mixed, low half enabled
    };

    logic clk = 1'b0;
    logic rst;
    logic wr_en;
    logic [1:0] wr_sel;
    logic [LINES-1:0] wr_data, pin, irq_line;
    logic irq_any;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_irq u_gpio_port_irq (
        .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .pin_i(pin), .irq_line_o(irq_line), .irq_any_o(irq_any)
    );

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] sel, logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic check(string req, logic [7:0] exp);
        checks++;
        if (irq_line !== exp || irq_any !== (exp != 0)) begin
            fails++;
            $display("FAIL %s: lines=%h any=%b expected lines=%h any=%b",
                     req, irq_line, irq_any, exp, exp != 0);
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; pin = 8'hA5;
        step(3);
        check("R1 reset", 8'h00);
        rst = 1'b0;
        step(4);
        check("R1 after reset, pins active", 8'h00);

        // Table walk: R2 R3 R4 R5 R6 R10
        foreach (VECS[i]) begin
            wr(2'd2, 8'h00);
            wr(2'd0, VECS[i].sense);
            wr(2'd1, VECS[i].pol);
            pin = VECS[i].pin_a;
            step(4);
            wr(2'd2, VECS[i].en);
            pin = VECS[i].pin_b;
            step(4);
            check($sformatf("R2/R3/R4/R10 vector %0d", i), VECS[i].exp);
        end

        // R6: caught rising edges persist after pins return
        wr(2'd2, 8'h00); wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
        pin = 8'h00; step(4);
        wr(2'd2, 8'hFF);
        pin = 8'h0F;
        step(2);
        check("R6 not yet caught at second edge", 8'h00);
        step(1);
        check("R6 caught at third edge", 8'h0F);
        pin = 8'h00; step(4);
        check("R6 held after pin returns", 8'h0F);

        // R7: acknowledge clears only bits written as one
        wr(2'd3, 8'h05);
        check("R7 partial acknowledge", 8'h0A);
        wr(2'd3, 8'h0A);
        check("R7 full acknowledge", 8'h00);

        // R8: edge on the same clock edge as its acknowledge stays caught
        pin = 8'h01;
        step(2);
        wr(2'd3, 8'h01);
        check("R8 edge beats acknowledge", 8'h01);
        wr(2'd3, 8'h01);
        check("R8 later acknowledge clears", 8'h00);

        // R9: polarity and sense rewrites with steady pins create no event
        wr(2'd1, 8'h00); step(3);
        check("R9 polarity flip, steady pins", 8'h00);
        wr(2'd1, 8'hFF); wr(2'd0, 8'h00); wr(2'd0, 8'hFF); step(3);
        check("R9 sense toggle, steady pins", 8'h00);

        // R4: disabling discards a caught edge
        pin = 8'h81; step(4);
        check("R4 edge caught on line 7", 8'h80);
        wr(2'd2, 8'h00);
        wr(2'd2, 8'hFF);
        check("R4 re-enable after disable shows nothing", 8'h00);

        // R5: level request timing and release without acknowledge
        wr(2'd2, 8'h00); wr(2'd0, 8'h00); wr(2'd1, 8'hFF);
        pin = 8'h00; step(4);
        wr(2'd2, 8'hFF);
        pin = 8'h10;
        step(1);
        check("R5 level not visible after one edge", 8'h00);
        step(1);
        check("R5 level visible after two edges", 8'h10);
        pin = 8'h00;
        step(2);
        check("R5 level drops with input", 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: bench did not finish, actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule